// File: doc/BRIEF.md
# Dual-Rail Strobe Quarter Logic Unit

This block is a clocked model of one quarter of a self-timed cellular cell. Every bit moves as a single-cycle strobe on one of two wires: a "zero" rail and a "one" rail. The strobe is both the value and the event, so the block has no valid or enable signal. A strobe from the internal neighbour writes a one-bit operand latch, called operand B. A strobe that reaches operand A starts an evaluation. A four-bit truth table then picks which output rail carries the single result strobe. The result fans out to both neighbours, which tap the same output pair.

Operand A is gathered through two independent selectors, one per rail. Each selector may take its rail from the external neighbour or from the internal neighbour, or it may block that rail. The operand B latch starts from a configuration bit at reset. Configuration inputs are held static while strobes flow.

Top module: `qlu_top`

## Requirements
- R1: While `rst_n` is low at a clock edge, `z_one`, `z_zero` and `rail_err` are low in the cycle that follows, and operand B takes the value of `cfg_b_init`.
- R2: A legal strobe on the operand B pair (exactly one of `int_b_one` or `int_b_zero` high) sets operand B to 1 for the one rail and to 0 for the zero rail. On its own it produces no output strobe.
- R3: A legal strobe on the effective A pair (exactly one rail high after selection) makes exactly one strobe on `z_one` or `z_zero` in the next cycle. That strobe lasts one cycle.
- R4: `cfg_fn` is the truth table of the result: bit 3 = Z(A=0,B=0), bit 2 = Z(0,1), bit 1 = Z(1,0), bit 0 = Z(1,1). Z=1 fires `z_one` and Z=0 fires `z_zero`. So 0000 always gives zero, 1111 always gives one, 0011 passes A, 0101 passes B, 0001 is AND, 0111 is OR, 0110 is XOR and 1001 is XNOR.
- R5: Each rail of operand A has its own 2-bit source code (`cfg_sel_one`, `cfg_sel_zero`): 0 takes the external rail and 1 takes the internal rail. The two rails may name different sources.
- R6: Source codes 2 and 3 block that rail. A blocked or unselected rail causes no output and no error, whatever it carries.
- R7: When operand B and operand A strobes arrive in the same cycle, the evaluation uses the newly arriving B value, and the latch keeps it.
- R8: Both rails high at once is illegal. This applies to the operand B pair, or to the effective A pair, even when its two rails come from different sources. An illegal pair raises `rail_err` for one cycle in the next cycle and is ignored: a bad B pair leaves the latch unchanged, and a bad A pair produces no output strobe.
- R9: In a cycle with no effective A strobe, the next cycle has both output rails low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_fn | input | 4 | Truth table of the result (R4 encoding) |
| cfg_sel_one | input | 2 | Source code for the A "one" rail |
| cfg_sel_zero | input | 2 | Source code for the A "zero" rail |
| cfg_b_init | input | 1 | Reset value of operand B |
| ext_a_one | input | 1 | External neighbour, "one" rail toward A |
| ext_a_zero | input | 1 | External neighbour, "zero" rail toward A |
| int_a_one | input | 1 | Internal neighbour, "one" rail toward A |
| int_a_zero | input | 1 | Internal neighbour, "zero" rail toward A |
| int_b_one | input | 1 | Internal neighbour, "one" rail into the B latch |
| int_b_zero | input | 1 | Internal neighbour, "zero" rail into the B latch |
| z_one | output | 1 | Result strobe, value 1 |
| z_zero | output | 1 | Result strobe, value 0 |
| rail_err | output | 1 | One-cycle flag for an illegal double-rail pair |

## Verification
Operand B has no output port, so its value can only be seen through an A strobe evaluated with a pass-B truth table. The latch checks for reset load, for B-only writes and for ignored bad B pairs therefore each follow their stimulus with such a probe. The hardest case is an illegal A pair made of two different sources. The stimulus sets the one rail to internal and the zero rail to external, then fires both in the same cycle while the raw external pair stays legal. The same-cycle A and B case is driven with a B value opposite to the stored one, so that using the stale value would show on the output.

// File: rtl/qlu_pkg.sv
// Shared types for the dual-rail quarter logic unit.
// Assumes two operands, so the truth table has four entries.
package qlu_pkg;

    // Source code for one operand-A rail; codes 2 and 3 block the rail.
    typedef enum logic [1:0] {
        SRC_EXT   = 2'd0,
        SRC_INT   = 2'd1,
        SRC_OFF   = 2'd2,
        SRC_OFF_B = 2'd3
    } src_e;

    // Index of each rail inside a two-wire pair vector.
    localparam int RAIL_ZERO = 0;
    localparam int RAIL_ONE  = 1;
    localparam int RAILS     = 2;

endpackage

// File: rtl/qlu_rail_sel.sv
// Per-rail operand-A source selector.
// Each rail of the A pair picks its external or internal wire on its own
// code, or is blocked. Purely combinational; assumes static codes.
module qlu_rail_sel
    import qlu_pkg::*;
#(
    parameter int SEL_W = 2
) (
    input  logic [SEL_W-1:0] sel_one,
    input  logic [SEL_W-1:0] sel_zero,
    input  logic [RAILS-1:0] ext_pair,
    input  logic [RAILS-1:0] int_pair,
    output logic [RAILS-1:0] a_pair
);

    logic [SEL_W-1:0] sel_vec [RAILS];

    assign sel_vec[RAIL_ZERO] = sel_zero;
    assign sel_vec[RAIL_ONE]  = sel_one;

    // One selector per rail, each decoding its own code.
    for (genvar r = 0; r < RAILS; r++) begin : g_rail
        always_comb begin
            unique case (sel_vec[r])
                SEL_W'(SRC_EXT): a_pair[r] = ext_pair[r];
                SEL_W'(SRC_INT): a_pair[r] = int_pair[r];
                default:         a_pair[r] = 1'b0;
            endcase
        end
    end

endmodule

// File: rtl/qlu_operand_latch.sv
// Operand B data latch.
// Holds the last legal strobe from the internal neighbour and forwards a
// same-cycle strobe straight to the evaluator. Loads its reset value from
// a configuration bit; assumes a synchronous active-low reset.
module qlu_operand_latch (
    input  logic clk,
    input  logic rst_n,
    input  logic init_val,
    input  logic b_one,
    input  logic b_zero,
    output logic b_eff,
    output logic b_bad
);

    logic b_cur;
    logic b_hit;

    // Classify the incoming pair.
    always_comb begin
        b_hit = b_one ^ b_zero;
        b_bad = b_one & b_zero;
        b_eff = b_hit ? b_one : b_cur;
    end

    // Latch update: reset value, else legal strobe, else hold.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            b_cur <= init_val;
        end else if (b_hit) begin
            b_cur <= b_one;
        end
    end

    assert_bad_b_holds_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (b_one && b_zero) |=> $stable(b_cur));

    assert_b_one_sets_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (b_one && !b_zero) |=> b_cur);

    assert_b_zero_clears_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (b_zero && !b_one) |=> !b_cur);

endmodule

// File: rtl/qlu_eval.sv
// Truth-table evaluator with registered dual-rail result.
// A legal A strobe looks up cfg_fn at {A,B} (bit 3 = Z(0,0) ... bit 0 =
// Z(1,1)) and fires one output rail in the next cycle. Illegal pairs raise
// the error flag and fire nothing.
module qlu_eval #(
    parameter  int N_IN = 2,
    localparam int FN_W = 1 << N_IN
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [FN_W-1:0] cfg_fn,
    input  logic            a_one,
    input  logic            a_zero,
    input  logic            b_val,
    input  logic            b_bad,
    output logic            z_one,
    output logic            z_zero,
    output logic            err
);

    logic            a_hit;
    logic            a_bad;
    logic [N_IN-1:0] idx;
    logic            z_bit;

    // Decode the A pair and look up the result bit.
    always_comb begin
        a_hit = a_one ^ a_zero;
        a_bad = a_one & a_zero;
        idx   = {a_one, b_val};
        z_bit = cfg_fn[~idx];
    end

    // Register one result strobe and the error flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            z_one  <= 1'b0;
            z_zero <= 1'b0;
            err    <= 1'b0;
        end else begin
            z_one  <= a_hit & z_bit;
            z_zero <= a_hit & ~z_bit;
            err    <= a_bad | b_bad;
        end
    end

    assert_single_rail_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({z_one, z_zero}));

    assert_a_answers_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (a_one ^ a_zero) |=> (z_one ^ z_zero));

    assert_bad_a_silent_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (a_one && a_zero) |=> (err && !z_one && !z_zero));

    assert_idle_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !(a_one || a_zero) |=> !(z_one || z_zero));

endmodule

// File: rtl/qlu_top.sv
// Dual-rail strobe quarter logic unit, top level.
// Wires the A-source selectors, the operand B latch and the evaluator.
// Assumes configuration inputs are static while strobes are present.
module qlu_top
    import qlu_pkg::*;
#(
    parameter  int N_IN  = 2,
    parameter  int SEL_W = 2,
    localparam int FN_W  = 1 << N_IN
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [FN_W-1:0]  cfg_fn,
    input  logic [SEL_W-1:0] cfg_sel_one,
    input  logic [SEL_W-1:0] cfg_sel_zero,
    input  logic             cfg_b_init,
    input  logic             ext_a_one,
    input  logic             ext_a_zero,
    input  logic             int_a_one,
    input  logic             int_a_zero,
    input  logic             int_b_one,
    input  logic             int_b_zero,
    output logic             z_one,
    output logic             z_zero,
    output logic             rail_err
);

    logic [RAILS-1:0] ext_pair;
    logic [RAILS-1:0] int_pair;
    logic [RAILS-1:0] a_pair;
    logic             b_eff;
    logic             b_bad;

    // Gather the raw A wires into rail-indexed pairs.
    always_comb begin
        ext_pair[RAIL_ONE]  = ext_a_one;
        ext_pair[RAIL_ZERO] = ext_a_zero;
        int_pair[RAIL_ONE]  = int_a_one;
        int_pair[RAIL_ZERO] = int_a_zero;
    end

    qlu_rail_sel #(.SEL_W(SEL_W)) u_sel (
        .sel_one  (cfg_sel_one),
        .sel_zero (cfg_sel_zero),
        .ext_pair (ext_pair),
        .int_pair (int_pair),
        .a_pair   (a_pair)
    );

    qlu_operand_latch u_blat (
        .clk      (clk),
        .rst_n    (rst_n),
        .init_val (cfg_b_init),
        .b_one    (int_b_one),
        .b_zero   (int_b_zero),
        .b_eff    (b_eff),
        .b_bad    (b_bad)
    );

    qlu_eval #(.N_IN(N_IN)) u_eval (
        .clk    (clk),
        .rst_n  (rst_n),
        .cfg_fn (cfg_fn),
        .a_one  (a_pair[RAIL_ONE]),
        .a_zero (a_pair[RAIL_ZERO]),
        .b_val  (b_eff),
        .b_bad  (b_bad),
        .z_one  (z_one),
        .z_zero (z_zero),
        .err    (rail_err)
    );

    assert_b_only_silent_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ((int_b_one ^ int_b_zero) && !(ext_a_one || ext_a_zero || int_a_one || int_a_zero))
        |=> !(z_one || z_zero));

    assert_blocked_silent_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_sel_one[SEL_W-1] && cfg_sel_zero[SEL_W-1] && !(int_b_one && int_b_zero))
        |=> !(z_one || z_zero || rail_err));

    assert_reset_quiet_R1: assert property (@(posedge clk)
        !rst_n |=> !(z_one || z_zero || rail_err));

endmodule

// File: tb/sim_qlu_top.sv
// Scoreboard bench: the driver task predicts each cycle and queues it;
// the monitor pops and compares one cycle after the capturing edge.
module sim_qlu_top;

    typedef struct {
        logic  z1;
        logic  z0;
        logic  err;
        string tag;
    } exp_t;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] cfg_fn = 4'b0101;
    logic [1:0] cfg_sel_one = 2'd0;
    logic [1:0] cfg_sel_zero = 2'd0;
    logic       cfg_b_init = 1'b0;
    logic       ext_a_one = 1'b0, ext_a_zero = 1'b0;
    logic       int_a_one = 1'b0, int_a_zero = 1'b0;
    logic       int_b_one = 1'b0, int_b_zero = 1'b0;
    logic       z_one, z_zero, rail_err;

    // Next-cycle configuration, applied by the driver after a falling edge.
    logic [3:0] nx_fn = 4'b0101;
    logic [1:0] nx_sel1 = 2'd0, nx_sel0 = 2'd0;

    exp_t   q[$];
    int     n_tests = 0;
    int     n_fail = 0;
    logic   model_b = 1'b0;
    bit     done = 1'b0;

    always #2.5 clk = ~clk;

    qlu_top u0 (
        .clk(clk), .rst_n(rst_n), .cfg_fn(cfg_fn),
        .cfg_sel_one(cfg_sel_one), .cfg_sel_zero(cfg_sel_zero),
        .cfg_b_init(cfg_b_init),
        .ext_a_one(ext_a_one), .ext_a_zero(ext_a_zero),
        .int_a_one(int_a_one), .int_a_zero(int_a_zero),
        .int_b_one(int_b_one), .int_b_zero(int_b_zero),
        .z_one(z_one), .z_zero(z_zero), .rail_err(rail_err)
    );

    // Monitor: compare one queued expectation per cycle.
    always begin
        @(posedge clk);
        #1;
        if (q.size() > 0) begin
            exp_t e;
            e = q.pop_front();
            n_tests++;
            if (z_one !== e.z1 || z_zero !== e.z0 || rail_err !== e.err) begin
                n_fail++;
                $display("FAIL %s: got z1=%b z0=%b err=%b, expected z1=%b z0=%b err=%b",
                         e.tag, z_one, z_zero, rail_err, e.z1, e.z0, e.err);
            end
        end
    end

    // Driver: one cycle of stimulus plus its predicted outcome.
    task automatic cyc(input logic ea1, input logic ea0, input logic ia1,
                       input logic ia0, input logic b1, input logic b0,
                       input string tag);
        exp_t e;
        logic a1, a0, zb;
        @(negedge clk);
        cfg_fn = nx_fn; cfg_sel_one = nx_sel1; cfg_sel_zero = nx_sel0;
        ext_a_one = ea1; ext_a_zero = ea0;
        int_a_one = ia1; int_a_zero = ia0;
        int_b_one = b1;  int_b_zero = b0;
        e.tag = tag;
        e.z1 = 1'b0; e.z0 = 1'b0; e.err = 1'b0;
        if (!rst_n) begin
            model_b = cfg_b_init;
        end else begin
            a1 = (nx_sel1 == 2'd0) ? ea1 : (nx_sel1 == 2'd1) ? ia1 : 1'b0;
            a0 = (nx_sel0 == 2'd0) ? ea0 : (nx_sel0 == 2'd1) ? ia0 : 1'b0;
            if (b1 ^ b0) model_b = b1;
            e.err = (b1 & b0) | (a1 & a0);
            if (a1 ^ a0) begin
                zb = nx_fn[3 - {a1, model_b}];
                e.z1 = zb; e.z0 = ~zb;
            end
        end
        q.push_back(e);
    endtask

    task automatic idle(input string tag);
        cyc(0, 0, 0, 0, 0, 0, tag);
    endtask

    // Reveal operand B through an external A strobe with the pass-B table.
    task automatic probe_b(input string tag);
        nx_fn = 4'b0101; nx_sel1 = 2'd0; nx_sel0 = 2'd0;
        cyc(1, 0, 0, 0, 0, 0, tag);
    endtask

    task automatic do_reset(input logic init);
        @(negedge clk);
        rst_n = 1'b0;
        cfg_b_init = init;
        idle("R1 reset");
        idle("R1 reset");
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        // R1: reset state and B initial value 1.
        do_reset(1'b1);
        probe_b("R1 init B=1");
        idle("R9 idle");

        // R2: B-only strobes produce no output, then change B.
        cyc(0, 0, 0, 0, 0, 1, "R2 B zero no output");
        probe_b("R2 B now 0");
        cyc(0, 0, 0, 0, 1, 0, "R2 B one no output");
        probe_b("R2 B now 1");

        // R3/R4: every table against every operand pair.
        for (int f = 0; f < 16; f++) begin
            for (int k = 0; k < 4; k++) begin
                nx_fn = 4'(f); nx_sel1 = 2'd0; nx_sel0 = 2'd0;
                cyc(0, 0, 0, 0, k[0], ~k[0], "R4 set B");
                cyc(k[1], ~k[1], 0, 0, 0, 0, "R3 R4 evaluate");
            end
        end
        nx_fn = 4'b0110;
        cyc(1, 0, 0, 0, 0, 0, "R4 XOR");
        idle("R9 idle");

        // R7: same-cycle A and B, B opposite to stored value.
        probe_b("R7 pre");
        nx_fn = 4'b0101;
        cyc(1, 0, 0, 0, 0, 1, "R7 new B=0 used");
        cyc(0, 1, 0, 0, 1, 0, "R7 new B=1 used");
        probe_b("R7 B kept");

        // R5/R6: one rail internal, zero rail external.
        nx_fn = 4'b0011; nx_sel1 = 2'd1; nx_sel0 = 2'd0;
        cyc(0, 0, 1, 0, 0, 0, "R5 one from internal");
        cyc(1, 0, 0, 0, 0, 0, "R6 external one not selected");
        cyc(0, 1, 0, 0, 0, 0, "R5 zero from external");
        cyc(0, 0, 0, 1, 0, 0, "R6 internal zero not selected");
        nx_sel1 = 2'd0; nx_sel0 = 2'd1;
        cyc(0, 0, 0, 1, 0, 0, "R5 zero from internal");
        cyc(1, 0, 0, 0, 0, 0, "R5 one from external");
        nx_sel1 = 2'd2; nx_sel0 = 2'd3;
        cyc(1, 0, 0, 0, 0, 0, "R6 blocked");
        cyc(0, 1, 0, 1, 0, 0, "R6 blocked");
        cyc(1, 1, 1, 1, 0, 0, "R6 blocked pairs no err");
        nx_sel1 = 2'd2; nx_sel0 = 2'd0;
        cyc(0, 1, 0, 0, 0, 0, "R6 only zero rail open");
        cyc(1, 0, 0, 0, 0, 0, "R6 one rail blocked");

        // R8: illegal pairs flag and are ignored.
        probe_b("R8 pre");
        cyc(0, 0, 0, 0, 1, 1, "R8 bad B pair");
        probe_b("R8 B unchanged");
        cyc(0, 0, 0, 0, 0, 1, "R8 B to 0");
        cyc(0, 0, 0, 0, 1, 1, "R8 bad B pair");
        probe_b("R8 B still 0");
        nx_fn = 4'b1111;
        cyc(1, 1, 0, 0, 0, 0, "R8 bad A pair no output");
        nx_sel1 = 2'd1; nx_sel0 = 2'd0;
        cyc(0, 1, 1, 0, 0, 0, "R8 bad A across sources");
        cyc(1, 1, 0, 0, 0, 0, "R8 raw ext pair, one rail unselected");
        idle("R9 idle");

        // R1: reset again with B initial value 0.
        do_reset(1'b0);
        probe_b("R1 init B=0");
        idle("R9 idle");
        idle("R9 idle");

        @(negedge clk);
        @(negedge clk);
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    // Watchdog: a hung run counts as one failure.
    initial begin
        #(5 * 20000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: got timeout, expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule